// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is an up/down counter with two personalities. As a timer it advances once per clock while it is enabled. As an encoder interface it follows two quadrature pins, A and B. It synchronises both pins and watches them for edges. It then steps the count up or down according to the phase between the two pins, using one of three edge-selection modes. The count always lies between zero and a programmable ceiling and wraps at both ends.

Software reaches the block through a small synchronous register port with one write strobe, an address, write data and a combinational read path. There are five registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | run bit in bit 0, read-only direction in bit 1, ceiling-buffer select in bit 2 |
| 1 | mode | 2-bit mode field |
| 2 | count | the counter value |
| 3 | ceiling | the live ceiling |
| 4 | update | trigger bit |

The ceiling can be replaced at once. It can also be staged in a shadow copy that only an update event makes live. An update event comes either from software or from a wrap of the count.

Top module: `qenc_timer`

## Requirements
- R1: After reset, control reads 0, mode reads 0, count reads 0 and ceiling reads all ones.
- R2: With mode 0 and the run bit (control bit 0) set, the count increases by exactly one every clock cycle.
- R3: While the run bit is 0, the count does not change in any mode, whatever the pins do.
- R4: Mode 1 steps on each edge of A only. When A and B are equal after the edge, the step is up; otherwise it is down. Edges of B alone cause no step.
- R5: Mode 2 steps on each edge of B only. When A and B differ after the edge, the step is up; otherwise it is down. Edges of A alone cause no step.
- R6: Mode 3 steps on every single-pin edge, using the rules of R4 for A and R5 for B. The {A,B} walk 00→01→11→10→00 therefore adds 4, and the reverse walk subtracts 4.
- R7: A sample in which both A and B changed at once causes no step.
- R8: Control bit 1 reads 1 after a downward step and 0 after an upward step. Mode 0 steps count as upward.
- R9: An upward step from the ceiling gives 0. A downward step from 0 gives the ceiling that is live after the step. Either wrap is an update event.
- R10: With control bit 2 at 0, a ceiling write takes effect at the next clock. With it at 1, the written value is held in a shadow copy and becomes live only on an update event (a write of 1 to update bit 0, or a wrap).
- R11: The update register always reads 0.
- R12: A count write whose value does not exceed the live ceiling loads the count, and it wins over a step in the same cycle. A count write above the ceiling is ignored.
- R13: If the live ceiling becomes smaller than the count, the count becomes 0, so the count never exceeds the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Quadrature input A, asynchronous |
| pin_b | input | 1 | Quadrature input B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for the addressed register (combinational) |

## Verification
A pin change reaches the count on the third clock edge after it is sampled. A wrongly decoded direction, or a step taken on a double change, therefore shows up on the count register three cycles after the stimulus. It then persists as a fixed offset from the expected value. A stale or wrongly applied ceiling appears on the ceiling read at the next clock. It also shows one step later, as a wrap to the wrong value. The bench compares every register read on every cycle against a behavioural model, so a divergence is reported in the cycle where it first appears.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int ADDR_W       = 3;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_DIR_BIT = 1;
    localparam int CTRL_BUF_BIT = 2;
    localparam int UPD_TRIG_BIT = 0;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_EDGE_A  = 2'd1,
        MODE_EDGE_B  = 2'd2,
        MODE_EDGE_AB = 2'd3
    } cnt_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_MODE   = 3'd1,
        RA_COUNT  = 3'd2,
        RA_CEIL   = 3'd3,
        RA_UPDATE = 3'd4
    } reg_addr_e;

    // present and previous synchronised samples of both pins
    typedef struct packed {
        logic a_now;
        logic a_old;
        logic b_now;
        logic b_old;
    } pin_view_t;

    typedef struct packed {
        logic step;
        logic down;
    } step_t;

    // direction of a single-pin quadrature edge, given the new levels
    function automatic logic down_for_a(input logic a, input logic b);
        return a ^ b;
    endfunction

    function automatic logic down_for_b(input logic a, input logic b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync
    import qenc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_a,
    input  logic      pin_b,
    output pin_view_t view
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw;
    logic [NCH-1:0] now_v;
    logic [NCH-1:0] old_v;

    assign raw = {pin_b, pin_a};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            // stages 0..SYNC_STAGES-1 resynchronise, the last one keeps history
            logic [SYNC_STAGES:0] shreg;
            always_ff @(posedge clk) begin
                if (rst) shreg <= '0;
                else     shreg <= {shreg[SYNC_STAGES-1:0], raw[ch]};
            end
            assign now_v[ch] = shreg[SYNC_STAGES-1];
            assign old_v[ch] = shreg[SYNC_STAGES];
        end
    endgenerate

    assign view.a_now = now_v[0];
    assign view.a_old = old_v[0];
    assign view.b_now = now_v[1];
    assign view.b_old = old_v[1];

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  cnt_mode_e mode,
    input  pin_view_t view,
    output step_t     st
);
    logic a_edge;
    logic b_edge;

    assign a_edge = view.a_now ^ view.a_old;
    assign b_edge = view.b_now ^ view.b_old;

    always_comb begin
        st = '0;
        if (run) begin
            unique case (mode)
                MODE_TIMER: begin
                    st.step = 1'b1;
                    st.down = 1'b0;
                end
                MODE_EDGE_A: begin
                    st.step = a_edge & ~b_edge;
                    st.down = down_for_a(view.a_now, view.b_now);
                end
                MODE_EDGE_B: begin
                    st.step = b_edge & ~a_edge;
                    st.down = down_for_b(view.a_now, view.b_now);
                end
                MODE_EDGE_AB: begin
                    st.step = a_edge ^ b_edge;
                    st.down = a_edge ? down_for_a(view.a_now, view.b_now)
                                     : down_for_b(view.a_now, view.b_now);
                end
                default: st = '0;
            endcase
        end
    end

    AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_TIMER && a_edge && b_edge) |-> !st.step); // R7

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !run |-> !st.step); // R3

endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buffered,
    input  step_t            st,
    input  logic             cnt_we,
    input  logic             ceil_we,
    input  logic             upd_req,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] ceil_q,
    output logic             down_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] ceil_nxt;
    logic [CNT_W-1:0] shadow_nxt;
    logic [CNT_W-1:0] cand;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             upd_evt;

    assign wrap    = st.step & ~cnt_we &
                     (st.down ? (cnt_q == '0) : (cnt_q >= ceil_q));
    assign upd_evt = upd_req | wrap;

    always_comb begin
        shadow_nxt = ceil_we ? wdata : shadow_q;
        if (ceil_we && !buffered) ceil_nxt = wdata;
        else if (upd_evt)         ceil_nxt = shadow_q;
        else                      ceil_nxt = ceil_q;
    end

    always_comb begin
        if (cnt_we)
            cand = (wdata <= ceil_q) ? wdata : cnt_q;
        else if (st.step && st.down)
            cand = (cnt_q == '0) ? ceil_nxt : cnt_q - CNT_ONE;
        else if (st.step)
            cand = wrap ? '0 : cnt_q + CNT_ONE;
        else
            cand = cnt_q;
        cnt_nxt = (cand > ceil_nxt) ? '0 : cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            ceil_q   <= CNT_TOP;
            shadow_q <= CNT_TOP;
            down_q   <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            ceil_q   <= ceil_nxt;
            shadow_q <= shadow_nxt;
            if (st.step) down_q <= st.down;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= ceil_q); // R13

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (st.step && !st.down && !cnt_we && cnt_q == ceil_q) |=> (cnt_q == '0)); // R9

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (st.step && st.down && !cnt_we && cnt_q == '0) |=> (cnt_q == ceil_q)); // R9

    AST_CEIL_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (ceil_we && !buffered) |=> (ceil_q == $past(wdata))); // R10

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !ceil_we && !upd_req && wdata <= ceil_q) |=> (cnt_q == $past(wdata))); // R12

endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);
    reg_addr_e        addr;
    logic             run_q;
    logic             buf_q;
    cnt_mode_e        mode_q;
    logic             ctrl_we;
    logic             mode_we;
    logic             cnt_we;
    logic             ceil_we;
    logic             upd_req;
    pin_view_t        view;
    step_t            st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ceil;
    logic             down;

    assign addr    = reg_addr_e'(reg_addr);
    assign ctrl_we = reg_we && addr == RA_CTRL;
    assign mode_we = reg_we && addr == RA_MODE;
    assign cnt_we  = reg_we && addr == RA_COUNT;
    assign ceil_we = reg_we && addr == RA_CEIL;
    assign upd_req = reg_we && addr == RA_UPDATE && reg_wdata[UPD_TRIG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            buf_q  <= 1'b0;
            mode_q <= MODE_TIMER;
        end else begin
            if (ctrl_we) begin
                run_q <= reg_wdata[CTRL_RUN_BIT];
                buf_q <= reg_wdata[CTRL_BUF_BIT];
            end
            if (mode_we) mode_q <= cnt_mode_e'(reg_wdata[1:0]);
        end
    end

    qenc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_a (pin_a),
        .pin_b (pin_b),
        .view  (view)
    );

    qenc_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .mode (mode_q),
        .view (view),
        .st   (st)
    );

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .buffered (buf_q),
        .st       (st),
        .cnt_we   (cnt_we),
        .ceil_we  (ceil_we),
        .upd_req  (upd_req),
        .wdata    (reg_wdata),
        .cnt_q    (cnt),
        .ceil_q   (ceil),
        .down_q   (down)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            RA_CTRL: begin
                reg_rdata[CTRL_RUN_BIT] = run_q;
                reg_rdata[CTRL_DIR_BIT] = down;
                reg_rdata[CTRL_BUF_BIT] = buf_q;
            end
            RA_MODE:  reg_rdata[1:0] = mode_q;
            RA_COUNT: reg_rdata = cnt;
            RA_CEIL:  reg_rdata = ceil;
            default:  reg_rdata = '0;
        endcase
    end

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_we && !ceil_we && !upd_req) |=> $stable(cnt)); // R3

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_q && mode_q == MODE_TIMER && !reg_we && cnt < ceil) |=> (cnt == $past(cnt) + 1'b1)); // R2

endmodule

// File: tb/qenc_timer_test.sv
`timescale 1ns/1ps
module qenc_timer_test;
    localparam int W    = 16;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pin_a = 1'b0;
    logic         pin_b = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd2;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;

    int    errs = 0;
    int    checks = 0;
    bit    done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    qenc_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // behavioural reference model
    int m_cnt, m_ceil, m_shadow, m_mode;
    bit m_en, m_pre, m_dir;
    bit pa[3];
    bit pb[3];

    always @(posedge clk) begin
        bit ae, be, stp, dn, cw, wrap, upd;
        int nc, nceil;
        if (rst) begin
            m_cnt = 0; m_ceil = MAXV; m_shadow = MAXV; m_mode = 0;
            m_en = 0; m_pre = 0; m_dir = 0;
            for (int i = 0; i < 3; i++) begin pa[i] = 0; pb[i] = 0; end
        end else begin
            ae = pa[1] != pa[2];
            be = pb[1] != pb[2];
            stp = 0; dn = 0;
            if (m_en) begin
                case (m_mode)
                    0: stp = 1;
                    1: if (ae && !be) begin stp = 1; dn = (pa[1] != pb[1]); end
                    2: if (be && !ae) begin stp = 1; dn = (pa[1] == pb[1]); end
                    default: if (ae != be) begin
                        stp = 1;
                        dn = ae ? (pa[1] != pb[1]) : (pa[1] == pb[1]);
                    end
                endcase
            end
            cw = reg_we && reg_addr == 2;
            wrap = stp && !cw && (dn ? (m_cnt == 0) : (m_cnt >= m_ceil));
            upd = wrap || (reg_we && reg_addr == 4 && reg_wdata[0]);
            nceil = m_ceil;
            if (reg_we && reg_addr == 3 && !m_pre) nceil = int'(reg_wdata);
            else if (upd) nceil = m_shadow;
            nc = m_cnt;
            if (cw) begin
                if (int'(reg_wdata) <= m_ceil) nc = int'(reg_wdata);
            end else if (stp) begin
                if (dn) nc = (m_cnt == 0) ? nceil : m_cnt - 1;
                else    nc = wrap ? 0 : m_cnt + 1;
            end
            if (nc > nceil) nc = 0;
            if (stp) m_dir = dn;
            if (reg_we && reg_addr == 3) m_shadow = int'(reg_wdata);
            if (reg_we && reg_addr == 0) begin m_en = reg_wdata[0]; m_pre = reg_wdata[2]; end
            if (reg_we && reg_addr == 1) m_mode = int'(reg_wdata[1:0]);
            m_cnt = nc; m_ceil = nceil;
            pa[2] = pa[1]; pa[1] = pa[0]; pa[0] = pin_a;
            pb[2] = pb[1]; pb[1] = pb[0]; pb[0] = pin_b;
        end
    end

    function automatic int mread(input int a);
        case (a)
            0: return (int'(m_pre) << 2) | (int'(m_dir) << 1) | int'(m_en);
            1: return m_mode;
            2: return m_cnt;
            3: return m_ceil;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(reg_rdata) != mread(int'(reg_addr))) begin
                errs++;
                $display("FAIL %s model compare addr %0d: actual %0h expected %0h",
                         tag, reg_addr, reg_rdata, mread(int'(reg_addr)));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1; reg_addr = 3'(a); reg_wdata = W'(d);
        @(posedge clk); #1;
        reg_we = 0; reg_addr = 3'd2;
    endtask

    task automatic chk(input int a, input int exp, input string req);
        @(posedge clk); #1;
        reg_addr = 3'(a);
        @(negedge clk);
        checks++;
        if (int'(reg_rdata) != exp) begin
            errs++;
            $display("FAIL %s addr %0d: actual %0h expected %0h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic setab(input bit a, input bit b);
        @(posedge clk); #1;
        pin_a = a; pin_b = b;
        repeat (4) @(posedge clk);
    endtask

    task automatic fwd();
        setab(0, 1); setab(1, 1); setab(1, 0); setab(0, 0);
    endtask

    task automatic rev();
        setab(1, 0); setab(1, 1); setab(0, 1); setab(0, 0);
    endtask

    task automatic span(input int exp_diff, input string req);
        int v1, v2;
        @(posedge clk); #1;
        reg_addr = 3'd2;
        @(negedge clk); v1 = int'(reg_rdata);
        repeat (10) @(negedge clk);
        v2 = int'(reg_rdata);
        checks++;
        if (v2 - v1 != exp_diff) begin
            errs++;
            $display("FAIL %s count change over 10 cycles: actual %0d expected %0d", req, v2 - v1, exp_diff);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog expired (all requirements): actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk(0, 0, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, MAXV, "R1");
        tag = "R11"; chk(4, 0, "R11");

        tag = "R2"; wr(0, 1); span(10, "R2");
        tag = "R3"; wr(0, 0); span(0, "R3");

        tag = "R12"; wr(2, 100); chk(2, 100, "R12");

        tag = "R4"; wr(1, 1); wr(0, 1);
        fwd(); chk(2, 102, "R4"); chk(0, 1, "R8");
        rev(); chk(2, 100, "R4"); chk(0, 3, "R8");

        tag = "R5"; wr(1, 2);
        fwd(); chk(2, 102, "R5");
        rev(); chk(2, 100, "R5");

        tag = "R6"; wr(1, 3);
        fwd(); chk(2, 104, "R6"); chk(0, 1, "R8");
        rev(); chk(2, 100, "R6"); chk(0, 3, "R8");

        tag = "R7";
        setab(1, 1); chk(2, 100, "R7");
        setab(0, 0); chk(2, 100, "R7");

        tag = "R3"; wr(0, 0);
        fwd(); chk(2, 100, "R3");
        wr(0, 1);

        tag = "R13"; wr(3, 5); chk(3, 5, "R10"); chk(2, 0, "R13");

        tag = "R9";
        setab(1, 0); chk(2, 5, "R9");
        setab(0, 0); chk(2, 0, "R9");

        tag = "R10"; wr(0, 5);
        wr(3, 7); chk(3, 5, "R10");
        wr(4, 1); chk(3, 7, "R10"); chk(4, 0, "R11");
        wr(3, 3); chk(3, 7, "R10");
        setab(1, 0); chk(3, 3, "R10"); chk(2, 3, "R9");

        // count write lands in the same cycle as a counting edge
        tag = "R12";
        @(posedge clk); #1; pin_a = 0; pin_b = 0;
        @(posedge clk);
        @(posedge clk); #1; reg_we = 1; reg_addr = 3'd2; reg_wdata = W'(2);
        @(posedge clk); #1; reg_we = 0;
        repeat (3) @(posedge clk);
        chk(2, 2, "R12");
        wr(2, 9); chk(2, 2, "R12");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule